// File: doc/BRIEF.md
# Address-Line Alias Test Engine

This engine checks the address wiring of a memory region for lines that are stuck or shorted together. It picks a reference word and, for every address bit at or above the word boundary, forms a partner address that differs from the reference in that one bit. Partners that fall outside the region under test are skipped.

For each partner inside the region, the engine does three accesses:

1. It reads the partner.
2. It writes the bitwise inverse of that value into the reference word.
3. It reads the partner a second time.

If the second read returns the inverse just written, the two addresses resolve to the same storage and the engine reports a fault.

The walk is done twice. The first pass uses the lowest word of the region as reference, so a single one travels through zero address bits. The second pass uses the word eight bytes below the region end, so a single zero travels through set bits. The second pass runs only if the first found nothing.

Software or a boot sequencer supplies a base and a size, pulses `start`, and waits for `done`. Every detected alias is reported as a one-cycle event carrying the reference address, the partner address and the flipped bit. A sticky fail flag summarises the outcome. Memory is reached through a simple request/acknowledge master port with one access outstanding.

Top module: `mlt_addr_line_test`

## Requirements
- R1: The flip mask starts at the bit whose value equals `WORD_BYTES` (bit 2 for 4-byte words) and doubles each step until it shifts out to zero. Every access address is word aligned. Each write (reference) address and its preceding partner read differ in exactly one bit, of weight at least `WORD_BYTES`.
- R2: A partner is visited only when base ≤ partner < base + size. No memory access ever falls outside that region.
- R3: Each visited partner causes exactly three accesses, in this order: a read of the partner, a write to the reference of the bitwise inverse of the read value, then a second read of the partner.
- R4: When the second partner read equals the inverted value written, `fault_valid` pulses for one cycle with `fault_ref`, `fault_partner` and `fault_mask`, and `fail` goes high. `fail` stays high until the next accepted start.
- R5: After a fault the walk continues through the remaining masks of the current pass, and further faults are reported too.
- R6: The first pass uses base as reference. The second pass uses base + size − 8 as reference.
- R7: The second pass is performed only if the first pass reported no fault.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. Each acknowledge completes one access, and read data is taken from `mem_rdata` in the acknowledge cycle.
- R9: `busy` is high from the cycle after an accepted start until the end of the run. `done` is a single-cycle pulse with `busy` low. A `start` seen while busy is ignored and does not disturb the run in progress.
- R10: After reset, `busy`, `done`, `fail`, `fault_valid` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| base_addr | input | ADDR_W | Region start byte address, word aligned |
| region_size | input | ADDR_W+1 | Region length in bytes, multiple of word, at least 8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky: an alias was found in this run |
| fault_valid | output | 1 | One-cycle alias report |
| fault_ref | output | ADDR_W | Reference address of the report |
| fault_partner | output | ADDR_W | Partner address of the report |
| fault_mask | output | ADDR_W | Flipped address bit of the report |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bound checker watches, on every cycle, the properties that need only local context:

- request stability while unacknowledged, and word alignment;
- containment of all accesses inside the latched region;
- a read opening each access group;
- the one-hot report mask and its agreement with the reported address pair;
- `fail` being raised and then held;
- the shape of `done`.

Whether an alias is actually found, whether the second pass is correctly suppressed or run, and which reference each pass uses depend on the memory's faulty wiring. Only the bench's scenarios can show these: it runs stuck-at and shorted address lines against a model of the walk.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WALK = 3'd1,
        ST_RD_A = 3'd2,
        ST_WR   = 3'd3,
        ST_RD_B = 3'd4
    } mlt_state_e;

endpackage

// File: rtl/mlt_partner.sv
// Partner address formation, region containment and mask stepping.
module mlt_partner #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   lim,
    output logic [ADDR_W-1:0] partner,
    output logic [ADDR_W-1:0] next_mask,
    output logic              in_range
);
    always_comb begin
        partner   = ref_addr ^ mask;
        in_range  = (partner >= base) && ({1'b0, partner} < lim);
        next_mask = {mask[ADDR_W-2:0], 1'b0};
    end
endmodule

// File: rtl/mlt_alias_cmp.sv
// Forms the inverted write value and judges whether the partner followed it.
module mlt_alias_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] first_rd,
    input  logic [DATA_W-1:0] second_rd,
    output logic [DATA_W-1:0] wr_val,
    output logic              alias_hit
);
    always_comb begin
        wr_val    = ~first_rd;
        alias_hit = (second_rd == wr_val);
    end
endmodule

// File: rtl/mlt_addr_line_test.sv
module mlt_addr_line_test
    import mlt_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int TOP_BACKOFF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   region_size,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_ref,
    output logic [ADDR_W-1:0] fault_partner,
    output logic [ADDR_W-1:0] fault_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] MASK_INIT = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W:0]   BACKOFF   = (ADDR_W+1)'(TOP_BACKOFF);

    typedef struct packed {
        mlt_state_e        st;
        logic              run;     // 0 = low reference pass, 1 = high
        logic              fail;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   lim;
        logic [ADDR_W-1:0] refa;
        logic [ADDR_W-1:0] mask;
        logic [DATA_W-1:0] first;
        logic              done;
        logic              fv;
        logic [ADDR_W-1:0] f_ref;
        logic [ADDR_W-1:0] f_par;
        logic [ADDR_W-1:0] f_mask;
    } eng_t;

    eng_t q, d;

    logic [ADDR_W-1:0] partner;
    logic [ADDR_W-1:0] next_mask;
    logic              in_range;
    logic [DATA_W-1:0] wr_val;
    logic              alias_hit;

    // Latched region, exposed for the bound checker.
    logic [ADDR_W-1:0] base_cur;
    logic [ADDR_W:0]   lim_cur;

    mlt_partner #(.ADDR_W(ADDR_W)) u_partner (
        .ref_addr  (q.refa),
        .mask      (q.mask),
        .base      (q.base),
        .lim       (q.lim),
        .partner   (partner),
        .next_mask (next_mask),
        .in_range  (in_range)
    );

    mlt_alias_cmp #(.DATA_W(DATA_W)) u_cmp (
        .first_rd  (q.first),
        .second_rd (mem_rdata),
        .wr_val    (wr_val),
        .alias_hit (alias_hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fv   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_WALK;
                    d.run  = 1'b0;
                    d.fail = 1'b0;
                    d.base = base_addr;
                    d.lim  = {1'b0, base_addr} + region_size;
                    d.refa = base_addr;
                    d.mask = MASK_INIT;
                end
            end
            ST_WALK: begin
                if (q.mask == '0) begin
                    if (!q.run && !q.fail) begin
                        d.run  = 1'b1;
                        d.refa = ADDR_W'(q.lim - BACKOFF);
                        d.mask = MASK_INIT;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end else if (in_range) begin
                    d.st = ST_RD_A;
                end else begin
                    d.mask = next_mask;
                end
            end
            ST_RD_A: begin
                if (mem_ack) begin
                    d.first = mem_rdata;
                    d.st    = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) d.st = ST_RD_B;
            end
            ST_RD_B: begin
                if (mem_ack) begin
                    if (alias_hit) begin
                        d.fv     = 1'b1;
                        d.fail   = 1'b1;
                        d.f_ref  = q.refa;
                        d.f_par  = partner;
                        d.f_mask = q.mask;
                    end
                    d.mask = next_mask;
                    d.st   = ST_WALK;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy          = (q.st != ST_IDLE);
        done          = q.done;
        fail          = q.fail;
        fault_valid   = q.fv;
        fault_ref     = q.f_ref;
        fault_partner = q.f_par;
        fault_mask    = q.f_mask;
        mem_req       = (q.st == ST_RD_A) || (q.st == ST_WR) || (q.st == ST_RD_B);
        mem_we        = (q.st == ST_WR);
        mem_addr      = (q.st == ST_WR) ? q.refa : partner;
        mem_wdata     = wr_val;
        base_cur      = q.base;
        lim_cur       = q.lim;
    end
endmodule

// File: rtl/mlt_addr_line_test_chk.sv
module mlt_addr_line_test_chk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_ref,
    input logic [ADDR_W-1:0] fault_partner,
    input logic [ADDR_W-1:0] fault_mask,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] base_cur,
    input logic [ADDR_W:0]   lim_cur
);
    localparam logic [ADDR_W-1:0] SUB_MASK = ADDR_W'(WORD_BYTES - 1);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & SUB_MASK) == '0));

    p_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (({1'b0, mem_addr} >= {1'b0, base_cur}) && ({1'b0, mem_addr} < lim_cur)));

    p_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_we);

    p_report_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ($onehot(fault_mask) && ((fault_ref ^ fault_partner) == fault_mask)
                         && ((fault_mask & SUB_MASK) == '0)));

    p_fail_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fail);

    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && busy) |=> fail);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind mlt_addr_line_test mlt_addr_line_test_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .fault_valid(fault_valid), .fault_ref(fault_ref), .fault_partner(fault_partner),
    .fault_mask(fault_mask), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .base_cur(base_cur), .lim_cur(lim_cur)
);

// File: tb/tb_mlt_addr_line_test.sv
`timescale 1ns/1ps
module tb_mlt_addr_line_test;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NWORDS = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   region_size = '0;
    logic          busy, done, fail, fault_valid;
    logic [AW-1:0] fault_ref, fault_partner, fault_mask;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    mlt_addr_line_test #(.ADDR_W(AW), .DATA_W(DW), .WORD_BYTES(4), .TOP_BACKOFF(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .region_size(region_size), .busy(busy), .done(done), .fail(fail),
        .fault_valid(fault_valid), .fault_ref(fault_ref), .fault_partner(fault_partner),
        .fault_mask(fault_mask), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;

    // Faulty memory: mode 0 ok, 1 stuck-0, 2 stuck-1, 3 wired-OR short, 4 wired-AND short.
    logic [DW-1:0] mem [NWORDS];
    logic [DW-1:0] sh  [NWORDS];
    int fmode = 0, fk = 0, fj = 0;

    int exp_ref[$], exp_par[$], exp_msk[$];
    int act_ref[$], act_par[$], act_msk[$];
    int exp_acc, exp_last_ref;
    int act_acc, bad_range, bad_order, bad_wdata, bad_mask;
    int first_wr, last_wr, phase;
    int cur_b, cur_s;
    logic [DW-1:0] last_rd;
    int rd_addr;
    int lat;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int phys(input int a);
        int w;
        int x;
        w = a;
        case (fmode)
            1: w = a & ~(1 << fk);
            2: w = a | (1 << fk);
            3: begin
                x = ((a >> fk) | (a >> fj)) & 1;
                w = (a & ~(1 << fk) & ~(1 << fj)) | (x << fk) | (x << fj);
            end
            4: begin
                x = ((a >> fk) & (a >> fj)) & 1;
                w = (a & ~(1 << fk) & ~(1 << fj)) | (x << fk) | (x << fj);
            end
            default: w = a;
        endcase
        return (w >> 2) & (NWORDS - 1);
    endfunction

    // Reference walk over the shadow memory, following R1..R6.
    task automatic model_walk(input int b, input int s, input int r);
        logic [DW-1:0] v1;
        logic [DW-1:0] v2;
        int p;
        for (int m = 4; m < (1 << AW); m = m << 1) begin
            p = r ^ m;
            if (p >= b && p < b + s) begin
                v1 = sh[phys(p)];
                sh[phys(r)] = ~v1;
                v2 = sh[phys(p)];
                exp_acc += 3;
                exp_last_ref = r;
                if (v2 == ~v1) begin
                    exp_ref.push_back(r);
                    exp_par.push_back(p);
                    exp_msk.push_back(m);
                end
            end
        end
    endtask

    // Memory responder and access monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat > 0) begin
                    lat--;
                end else begin
                    act_acc++;
                    if (int'(mem_addr) < cur_b || int'(mem_addr) >= cur_b + cur_s) bad_range++;
                    if (mem_we != (phase == 1)) bad_order++;
                    if (mem_we) begin
                        if (mem_wdata != ~last_rd) bad_wdata++;
                        if ($countones(rd_addr ^ int'(mem_addr)) != 1 || ((rd_addr ^ int'(mem_addr)) & 3) != 0)
                            bad_mask++;
                        if (first_wr < 0) first_wr = int'(mem_addr);
                        last_wr = int'(mem_addr);
                        mem[phys(int'(mem_addr))] = mem_wdata;
                    end else begin
                        mem_rdata = mem[phys(int'(mem_addr))];
                        if (phase == 0) begin
                            last_rd = mem_rdata;
                            rd_addr = int'(mem_addr);
                        end
                    end
                    phase = (phase == 2) ? 0 : phase + 1;
                    mem_ack = 1'b1;
                    lat = $urandom % 3;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (fault_valid) begin
                act_ref.push_back(int'(fault_ref));
                act_par.push_back(int'(fault_partner));
                act_msk.push_back(int'(fault_mask));
            end
        end
    end

    task automatic run_test(input string name, input int b, input int s, input int mode,
                            input int k, input int j, input bit poke);
        int cyc;
        bit exp_fail;
        fmode = mode; fk = k; fj = j;
        for (int i = 0; i < NWORDS; i++) begin
            mem[i] = $urandom;
            sh[i]  = mem[i];
        end
        exp_ref.delete(); exp_par.delete(); exp_msk.delete();
        act_ref.delete(); act_par.delete(); act_msk.delete();
        exp_acc = 0; exp_last_ref = -1;
        model_walk(b, s, b);
        if (exp_ref.size() == 0) model_walk(b, s, (b + s - 8) & ((1 << AW) - 1));
        exp_fail = (exp_ref.size() != 0);
        act_acc = 0; bad_range = 0; bad_order = 0; bad_wdata = 0; bad_mask = 0;
        first_wr = -1; last_wr = -1; phase = 0; lat = 0;
        cur_b = b; cur_s = s;

        @(negedge clk);
        base_addr = AW'(b);
        region_size = (AW+1)'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 6) begin
                start = 1'b1;
                base_addr = AW'((b + 256) & 12'hffc);
                region_size = 13'd16;
            end
            if (poke && cyc == 7) start = 1'b0;
        end
        chk(done == 1'b1, "R9", {name, " done seen"}, int'(done), 1);
        chk(busy == 1'b0, "R9", {name, " idle at done"}, int'(busy), 0);
        chk(fail == exp_fail, "R4", {name, " fail flag"}, int'(fail), int'(exp_fail));
        chk(act_ref.size() == exp_ref.size(), "R5", {name, " fault count"}, act_ref.size(), exp_ref.size());
        for (int i = 0; i < exp_ref.size() && i < act_ref.size(); i++) begin
            chk(act_ref[i] == exp_ref[i], "R4", {name, " fault ref"}, act_ref[i], exp_ref[i]);
            chk(act_par[i] == exp_par[i], "R4", {name, " fault partner"}, act_par[i], exp_par[i]);
            chk(act_msk[i] == exp_msk[i], "R1", {name, " fault mask"}, act_msk[i], exp_msk[i]);
        end
        chk(act_acc == exp_acc, "R7", {name, " access count"}, act_acc, exp_acc);
        chk(bad_range == 0, "R2", {name, " out-of-region accesses"}, bad_range, 0);
        chk(bad_order == 0, "R3", {name, " access order"}, bad_order, 0);
        chk(bad_wdata == 0, "R3", {name, " inverse write data"}, bad_wdata, 0);
        chk(bad_mask == 0, "R1", {name, " single-bit partner"}, bad_mask, 0);
        if (exp_acc > 0) begin
            chk(first_wr == b, "R6", {name, " first-pass reference"}, first_wr, b);
            chk(last_wr == exp_last_ref, "R6", {name, " last reference"}, last_wr, exp_last_ref);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9", {name, " done single cycle"}, int'(done), 0);
        chk(fail == exp_fail, "R4", {name, " fail held after run"}, int'(fail), int'(exp_fail));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int b;
        int s;
        int md;
        int k;
        int j;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !fault_valid && !mem_req, "R10", "reset outputs",
            {busy, done, fail, fault_valid, mem_req}, 0);
        rst_n = 1'b1;

        run_test("clean full", 0, 4096, 0, 0, 0, 1'b0);
        run_test("stuck0 bit5", 0, 4096, 1, 5, 0, 1'b0);          // R7: no second pass
        run_test("stuck1 bit9", 0, 2048, 2, 9, 0, 1'b0);
        run_test("or-short hi pass", 0, 2048, 3, 5, 7, 1'b0);      // R6: only second pass fails
        run_test("and-short", 0, 4096, 4, 3, 10, 1'b0);            // R5: several faults
        run_test("partial region", 12'h340, 12'h1a8, 1, 6, 0, 1'b0); // R2: partners skipped
        run_test("min region", 12'h7f8, 8, 0, 0, 0, 1'b0);
        run_test("start while busy", 12'h100, 12'h400, 2, 4, 0, 1'b1); // R9

        for (int t = 0; t < 14; t++) begin
            b  = ($urandom % 1000) * 4;
            s  = 8 + ($urandom % ((4096 - b - 8) / 4 + 1)) * 4;
            md = $urandom % 5;
            k  = 2 + $urandom % 10;
            j  = 2 + $urandom % 10;
            if (j == k) j = (k == 11) ? 2 : k + 1;
            run_test("random", b, s, md, k, j, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule